// File: doc/BRIEF.md
# Variable-Length Instruction Cycle Sequencer

This block generates the control steps for a small 8-bit accumulator machine. Instructions do not share a single fixed fetch/decode/execute count. Each of the 32 opcodes has its own length of one to five clocks, taken from a lookup table. The sequencer walks a one-hot step index through that many clocks. It flags the final clock and pulses a fetch-done strobe so the next instruction can be fetched. It also advances an 8-bit program counter once per completed instruction.

The no-operation opcode has a switchable fast path: with the option set it finishes in a single clock, otherwise it takes two. The opcode and the fast-path option are captured in the first clock of an instruction. Later changes on those inputs have no effect until the next instruction begins. A stall input freezes all progress. The block has no streaming data path, so every pin is a plain level control or status signal and there is no back-pressure handshake.

Top module: `vlen_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge (synchronous, active high), the next state is step 0 (`step_oh` = 5'b00001) and `pc` = 0. The first instruction's step 0 is the clock right after reset is released.
- R2: `step_oh` is always one-hot. Bit k is set during the (k+1)-th unstalled clock of an instruction.
- R3: `last_step` and `fetch_done` are high only during the final clock of an instruction. After that edge `step_oh` returns to 5'b00001.
- R4: Instruction length comes from a 32-entry table of 3-bit values. By default, the table gives these lengths:
  - opcode 0 has 2;
  - opcodes 1 to 28 have ((op-1) mod 4)+1;
  - opcode 29 has 5;
  - opcode 30 holds 7;
  - opcode 31 holds 0.
- R5: An entry of 0 or of more than 5 is treated as length 5.
- R6: Opcode 0 (no-operation) with `fast_nop_en` high lasts exactly one clock.
- R7: Opcode 0 with `fast_nop_en` low lasts exactly two clocks.
- R8: `opcode_in` and `fast_nop_en` are sampled in step 0. Changing them in any later step of the same instruction does not change its length.
- R9: `pc` increments by one, modulo 256, on the edge ending an instruction, and holds otherwise.
- R10: While `stall` is high, `step_oh` and `pc` keep their values and `fetch_done` is low. `last_step` still shows whether the current step is final.
- R11: `instr_start` is high exactly during step 0 of each instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freezes step index and program counter |
| fast_nop_en | input | 1 | Selects the one-clock no-operation path |
| opcode_in | input | 5 | Opcode from the instruction register |
| step_oh | output | 5 | One-hot current step index |
| instr_start | output | 1 | High during step 0 |
| last_step | output | 1 | High during the final step of the instruction |
| fetch_done | output | 1 | Final step and not stalled: instruction completes this edge |
| pc | output | 8 | Program counter |

## Verification
The bench runs opcodes of every length from one to five and checks each step's one-hot code against its position. This separates an off-by-one ending from a wrong shift order. The two out-of-range table entries (7 and 0) are run next to a true length of 5, which shows whether clamping covers both ends. The no-operation opcode is run with the option both on and off. Further runs scramble the opcode and option after step 0, or stall in the first, a middle and the final step. These expose live rather than latched decoding, and a counter or PC that creeps forward under stall. A run of 260 one-clock instructions carries the program counter through its wrap.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int SEQ_OP_W   = 5;
  localparam int SEQ_OPS    = 1 << SEQ_OP_W;
  localparam int SEQ_MAX    = 5;
  localparam int SEQ_LEN_W  = $clog2(SEQ_MAX + 1);
  localparam int SEQ_PC_W   = 8;

  typedef logic [SEQ_LEN_W-1:0] seq_len_t;

  // Default per-opcode length table; entries 30 and 31 are deliberately out of range.
  function automatic logic [SEQ_OPS*SEQ_LEN_W-1:0] default_len_map();
    logic [SEQ_OPS*SEQ_LEN_W-1:0] m;
    m = '0;
    for (int i = 0; i < SEQ_OPS; i++) begin
      seq_len_t v;
      if (i == 0)       v = seq_len_t'(2);
      else if (i <= 28) v = seq_len_t'(((i - 1) % 4) + 1);
      else if (i == 29) v = seq_len_t'(5);
      else if (i == 30) v = seq_len_t'(7);
      else              v = seq_len_t'(0);
      m[i*SEQ_LEN_W +: SEQ_LEN_W] = v;
    end
    return m;
  endfunction
endpackage

// File: rtl/seq_op_hold.sv
module seq_op_hold #(
  parameter int OP_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            at_start,
  input  logic            stall,
  input  logic [OP_W-1:0] op_live,
  input  logic            fast_live,
  output logic [OP_W-1:0] op_eff,
  output logic            fast_eff
);
  logic [OP_W-1:0] op_q;
  logic            fast_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= '0;
      fast_q <= 1'b0;
    end else if (at_start && !stall) begin
      op_q   <= op_live;
      fast_q <= fast_live;
    end
  end

  // In step 0 the live inputs decide; afterwards the captured copy does.
  assign op_eff   = at_start ? op_live   : op_q;
  assign fast_eff = at_start ? fast_live : fast_q;
endmodule

// File: rtl/seq_len_lookup.sv
module seq_len_lookup #(
  parameter int OP_W         = 5,
  parameter int LEN_W        = 3,
  parameter int MAX_STEPS    = 5,
  parameter int NOP_OP       = 0,
  parameter int NOP_SLOW_LEN = 2,
  parameter logic [(1<<OP_W)*LEN_W-1:0] LEN_MAP = '0
) (
  input  logic [OP_W-1:0]  op,
  input  logic             fast_nop,
  output logic [LEN_W-1:0] len
);
  localparam int NUM_OPS = 1 << OP_W;

  logic [LEN_W-1:0] clamped [NUM_OPS];

  genvar g;
  generate
    for (g = 0; g < NUM_OPS; g++) begin : g_entry
      logic [LEN_W-1:0] raw;
      assign raw = LEN_MAP[g*LEN_W +: LEN_W];
      assign clamped[g] = (raw == '0 || raw > LEN_W'(MAX_STEPS)) ? LEN_W'(MAX_STEPS) : raw;
    end
  endgenerate

  always_comb begin
    if (op == OP_W'(NOP_OP))
      len = fast_nop ? LEN_W'(1) : LEN_W'(NOP_SLOW_LEN);
    else
      len = clamped[op];
  end
endmodule

// File: rtl/seq_step_ctr.sv
module seq_step_ctr #(
  parameter int MAX_STEPS = 5,
  parameter int LEN_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stall,
  input  logic [LEN_W-1:0]     len,
  output logic [MAX_STEPS-1:0] step_q,
  output logic                 last
);
  logic [MAX_STEPS-1:0] final_sel;
  logic [MAX_STEPS-1:0] step_d;

  genvar i;
  generate
    for (i = 0; i < MAX_STEPS; i++) begin : g_step
      assign final_sel[i] = (len == LEN_W'(i + 1));
      if (i == 0) begin : g_first
        assign step_d[i] = last;
      end else begin : g_rest
        assign step_d[i] = last ? 1'b0 : step_q[i-1];
      end
    end
  endgenerate

  assign last = |(step_q & final_sel);

  always_ff @(posedge clk) begin
    if (rst)         step_q <= MAX_STEPS'(1);
    else if (!stall) step_q <= step_d;
  end
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            advance,
  output logic [PC_W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)          pc <= '0;
    else if (advance) pc <= pc + PC_W'(1);
  end
endmodule

// File: rtl/vlen_sequencer.sv
module vlen_sequencer
  import seq_pkg::*;
#(
  parameter int OP_W         = SEQ_OP_W,
  parameter int MAX_STEPS    = SEQ_MAX,
  parameter int PC_W         = SEQ_PC_W,
  parameter int NOP_OP       = 0,
  parameter int NOP_SLOW_LEN = 2,
  parameter logic [(1<<SEQ_OP_W)*SEQ_LEN_W-1:0] LEN_MAP = default_len_map()
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stall,
  input  logic                 fast_nop_en,
  input  logic [OP_W-1:0]      opcode_in,
  output logic [MAX_STEPS-1:0] step_oh,
  output logic                 instr_start,
  output logic                 last_step,
  output logic                 fetch_done,
  output logic [PC_W-1:0]      pc
);
  localparam int LEN_W = $clog2(MAX_STEPS + 1);

  logic [OP_W-1:0]  op_eff;
  logic             fast_eff;
  logic [LEN_W-1:0] cur_len;

  assign instr_start = step_oh[0];

  seq_op_hold #(.OP_W(OP_W)) u_hold (
    .clk(clk), .rst(rst), .at_start(instr_start), .stall(stall),
    .op_live(opcode_in), .fast_live(fast_nop_en),
    .op_eff(op_eff), .fast_eff(fast_eff)
  );

  seq_len_lookup #(
    .OP_W(OP_W), .LEN_W(LEN_W), .MAX_STEPS(MAX_STEPS),
    .NOP_OP(NOP_OP), .NOP_SLOW_LEN(NOP_SLOW_LEN), .LEN_MAP(LEN_MAP)
  ) u_len (
    .op(op_eff), .fast_nop(fast_eff), .len(cur_len)
  );

  seq_step_ctr #(.MAX_STEPS(MAX_STEPS), .LEN_W(LEN_W)) u_step (
    .clk(clk), .rst(rst), .stall(stall), .len(cur_len),
    .step_q(step_oh), .last(last_step)
  );

  assign fetch_done = last_step && !stall;

  seq_pc #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst(rst), .advance(fetch_done), .pc(pc)
  );
endmodule

// File: rtl/vlen_sequencer_chk.sv
module vlen_sequencer_chk #(
  parameter int MAX_STEPS = 5,
  parameter int PC_W      = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 stall,
  input logic [MAX_STEPS-1:0] step_oh,
  input logic                 instr_start,
  input logic                 last_step,
  input logic                 fetch_done,
  input logic [PC_W-1:0]      pc
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (step_oh == MAX_STEPS'(1) && pc == '0));

  // R2
  step_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(step_oh) == 1);

  // R3
  wrap_to_first_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_done |=> step_oh[0]);

  // R9
  pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_done |=> pc == PC_W'($past(pc) + PC_W'(1)));

  // R10
  stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(step_oh) && $stable(pc)));

  // R11
  no_early_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!last_step && !stall) |=> !instr_start);
endmodule

bind vlen_sequencer vlen_sequencer_chk #(.MAX_STEPS(MAX_STEPS), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .step_oh(step_oh),
  .instr_start(instr_start), .last_step(last_step),
  .fetch_done(fetch_done), .pc(pc)
);

// File: tb/vlen_sequencer_bench.sv
module vlen_sequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stall = 1'b0;
  logic       fast_nop_en = 1'b0;
  logic [4:0] opcode_in = 5'd1;
  logic [4:0] step_oh;
  logic       instr_start, last_step, fetch_done;
  logic [7:0] pc;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_pc = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlen_sequencer u_vlen_sequencer (
    .clk(clk), .rst(rst), .stall(stall), .fast_nop_en(fast_nop_en),
    .opcode_in(opcode_in), .step_oh(step_oh), .instr_start(instr_start),
    .last_step(last_step), .fetch_done(fetch_done), .pc(pc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected length per the default table (R4, R5)
  function automatic int spec_len(input int op, input bit fast);
    int v;
    if (op == 0) return fast ? 1 : 2;
    if (op <= 28) v = ((op - 1) % 4) + 1;
    else if (op == 29) v = 5;
    else if (op == 30) v = 7;
    else v = 0;
    if (v == 0 || v > 5) v = 5;
    return v;
  endfunction

  // Runs one instruction from its step 0 (caller is at a negedge in step 0).
  task automatic run_instr(input int op, input bit fast, input int exp_len,
                           input int stall_at, input int stall_n,
                           input bit scramble, input string req);
    opcode_in = 5'(op);
    fast_nop_en = fast;
    for (int k = 0; k < exp_len; k++) begin
      #1;
      chk(step_oh == 5'(1 << k), {req, " R2 step"}, step_oh, 1 << k);
      chk(last_step == (k == exp_len - 1), {req, " R3 last_step"}, last_step, k == exp_len - 1);
      chk(fetch_done == (k == exp_len - 1), {req, " R3 fetch_done"}, fetch_done, k == exp_len - 1);
      chk(instr_start == (k == 0), {req, " R11 start"}, instr_start, k == 0);
      chk(pc == exp_pc, {req, " R9 pc hold"}, pc, exp_pc);
      if (k == stall_at) begin
        stall = 1'b1;
        #1;
        chk(fetch_done == 1'b0, "R10 fetch_done under stall", fetch_done, 0);
        chk(last_step == (k == exp_len - 1), "R10 last_step under stall", last_step, k == exp_len - 1);
        for (int s = 0; s < stall_n; s++) begin
          @(posedge clk); @(negedge clk); #1;
          chk(step_oh == 5'(1 << k), "R10 step frozen", step_oh, 1 << k);
          chk(pc == exp_pc, "R10 pc frozen", pc, exp_pc);
        end
        stall = 1'b0;
      end
      @(posedge clk); @(negedge clk);
      if (scramble) begin
        opcode_in = ~5'(op);
        fast_nop_en = ~fast;
      end
    end
    exp_pc = exp_pc + 8'd1;
    #1;
    chk(step_oh == 5'd1, {req, " R3 back to step 0"}, step_oh, 1);
    chk(pc == exp_pc, {req, " R9 pc advance"}, pc, exp_pc);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_pc = 8'd0;
    #1;
    chk(step_oh == 5'd1, "R1 step after reset", step_oh, 1);
    chk(pc == 8'd0, "R1 pc after reset", pc, 0);
    chk(instr_start == 1'b1, "R1 R11 start after reset", instr_start, 1);
  endtask

  task automatic t_lengths();
    for (int op = 1; op <= 8; op++)
      run_instr(op, 1'b0, spec_len(op, 1'b0), -1, 0, 1'b0, "R4 length");
    run_instr(29, 1'b0, 5, -1, 0, 1'b0, "R4 length five");
  endtask

  task automatic t_clamp();
    run_instr(30, 1'b0, 5, -1, 0, 1'b0, "R5 clamp entry 7");
    run_instr(31, 1'b1, 5, -1, 0, 1'b0, "R5 clamp entry 0");
  endtask

  task automatic t_nop();
    run_instr(0, 1'b1, 1, -1, 0, 1'b0, "R6 fast nop");
    run_instr(0, 1'b1, 1, -1, 0, 1'b0, "R6 fast nop back-to-back");
    run_instr(0, 1'b0, 2, -1, 0, 1'b0, "R7 slow nop");
  endtask

  task automatic t_midchange();
    run_instr(2, 1'b0, 2, -1, 0, 1'b1, "R8 op change");
    run_instr(4, 1'b0, 4, -1, 0, 1'b1, "R8 op change long");
    run_instr(0, 1'b0, 2, -1, 0, 1'b1, "R8 fast flag change");
  endtask

  task automatic t_stall();
    run_instr(4, 1'b0, 4, 2, 3, 1'b0, "R10 stall mid");
    run_instr(3, 1'b0, 3, 2, 2, 1'b0, "R10 stall last");
    run_instr(1, 1'b0, 1, 0, 2, 1'b0, "R10 stall first");
  endtask

  task automatic t_pc_wrap();
    for (int i = 0; i < 260; i++) begin
      opcode_in = 5'd0;
      fast_nop_en = 1'b1;
      @(posedge clk); @(negedge clk);
      exp_pc = exp_pc + 8'd1;
    end
    #1;
    chk(pc == exp_pc, "R9 pc wrap", pc, exp_pc);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_lengths();
    t_clamp();
    t_nop();
    t_midchange();
    t_stall();
    t_pc_wrap();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule